// File: doc/BRIEF.md
# Hardened Cross-Checked Saturating Counter

The block holds a count in two registers. The primary register holds the count itself. A shadow register counts the other way, so that in a fault-free design the two always add up to the all-ones value of the configured width. A combinational comparator watches that sum. If any bit of either register is corrupted, the error output rises in the same cycle.

The count can be cleared to a parameterised base value, loaded with an arbitrary value, or moved up or down by a variable step. Both directions saturate: the count stops at the limits and never wraps. Every change is staged. A preview output always shows the value the count would take. The registers take that value only on a cycle where the commit strobe is high, so the surrounding logic can inspect or discard a pending update.

The reset is synchronous and active high. It loads the base value into the primary register and its complement into the shadow register.

Top module: `hcnt_top`

## Requirements
- R1: On the clock edge where `rst` is high, `cnt` becomes `RST_VAL` and `err` goes low. The design has `RST_VAL` = 0 by default; the bench uses 3.
- R2: A committed `clr` loads `cnt` with `RST_VAL`. It takes priority over `set`, `inc` and `dec`.
- R3: A committed `set` with `clr` low loads `cnt` with `set_val`. It takes priority over `inc` and `dec`.
- R4: A committed `inc` (with `dec`, `clr` and `set` low) adds `step` to `cnt` and saturates at all-ones. This holds even when `step` exceeds the headroom left.
- R5: A committed `dec` (with `inc`, `clr` and `set` low) subtracts `step` from `cnt` and saturates at zero. This holds even when `step` exceeds the count.
- R6: `inc` and `dec` high together, with `clr` and `set` low, leave the count unchanged.
- R7: `cnt_next` shows, in the same cycle, the value that `cnt` takes at the next edge if `commit` is high.
- R8: While `commit` is low, `cnt` holds, whatever `clr`, `set`, `inc` or `dec` request.
- R9: `err` is high in any cycle in which the primary count plus the shadow count, taken modulo 2^W, differs from 2^W-1. A corrupted shadow register raises it in the same cycle.
- R10: In fault-free operation the shadow register tracks the complement of the count, so `err` stays low through every clear, set, step and saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Request to return to the base value |
| set | input | 1 | Request to load `set_val` |
| set_val | input | W | Value used by a set request |
| inc | input | 1 | Request to step upward |
| dec | input | 1 | Request to step downward |
| step | input | W | Step amount |
| commit | input | 1 | Writes the pending update into both registers |
| cnt | output | W | Current count (primary register) |
| cnt_next | output | W | Value of the count after a commit |
| err | output | 1 | Primary and shadow registers disagree |

## Verification
`cnt_next` and `err` are combinational, so they are due within the cycle in which the inputs or register contents change. The bench drives inputs on the falling edge and samples both a nanosecond later. `cnt` passes through one register, so its new value is due after the next rising edge; the bench samples it one nanosecond after that edge, before any new stimulus. For the fault case, the shadow register is overwritten mid-cycle and `err` is checked before the next edge. After that, a committed clear must bring `err` low again by the following cycle.

// File: rtl/hcnt_pkg.sv
package hcnt_pkg;

    // Resolved update for one cycle, after priority is applied.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_UP    = 3'd3,
        OP_DOWN  = 3'd4
    } op_e;

    typedef struct packed {
        logic clr;
        logic set;
        logic inc;
        logic dec;
    } req_t;

    // Priority: clear, then load, then a single direction.
    function automatic op_e resolve_op(req_t r);
        if (r.clr)              return OP_CLEAR;
        else if (r.set)         return OP_LOAD;
        else if (r.inc && !r.dec) return OP_UP;
        else if (r.dec && !r.inc) return OP_DOWN;
        else                    return OP_HOLD;
    endfunction

endpackage

// File: rtl/hcnt_decode.sv
module hcnt_decode
    import hcnt_pkg::*;
(
    input  logic clr,
    input  logic set,
    input  logic inc,
    input  logic dec,
    output op_e  op
);
    req_t req;

    always_comb begin
        req.clr = clr;
        req.set = set;
        req.inc = inc;
        req.dec = dec;
        op      = resolve_op(req);
    end
endmodule

// File: rtl/hcnt_lane.sv
// One count register. PRIMARY=1 moves with the requested direction;
// PRIMARY=0 moves against it and holds the complement values.
module hcnt_lane
    import hcnt_pkg::*;
#(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter bit          PRIMARY = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         commit,
    input  op_e          op,
    input  logic [W-1:0] set_val,
    input  logic [W-1:0] step,
    output logic [W-1:0] val_next,
    output logic [W-1:0] val_q
);
    localparam logic [W-1:0] ONES   = {W{1'b1}};
    localparam logic [W-1:0] BASE   = PRIMARY ? RST_VAL : (ONES - RST_VAL);

    function automatic logic [W-1:0] sat_add(logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[W] ? ONES : s[W-1:0];
    endfunction

    function automatic logic [W-1:0] sat_sub(logic [W-1:0] a, logic [W-1:0] b);
        return (a < b) ? '0 : (a - b);
    endfunction

    logic [W-1:0] load_val;
    logic [W-1:0] up_val;
    logic [W-1:0] down_val;

    generate
        if (PRIMARY) begin : g_fwd
            always_comb begin
                load_val = set_val;
                up_val   = sat_add(val_q, step);
                down_val = sat_sub(val_q, step);
            end
        end else begin : g_rev
            always_comb begin
                load_val = ONES - set_val;
                up_val   = sat_sub(val_q, step);
                down_val = sat_add(val_q, step);
            end
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_CLEAR: val_next = BASE;
            OP_LOAD:  val_next = load_val;
            OP_UP:    val_next = up_val;
            OP_DOWN:  val_next = down_val;
            default:  val_next = val_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            val_q <= BASE;
        else if (commit)
            val_q <= val_next;
    end
endmodule

// File: rtl/hcnt_check.sv
module hcnt_check #(
    parameter int W = 2
) (
    input  logic [W-1:0] pri,
    input  logic [W-1:0] sec,
    output logic         mismatch
);
    localparam logic [W-1:0] ONES = {W{1'b1}};
    logic [W-1:0] total;

    always_comb begin
        total    = pri + sec;
        mismatch = (total != ONES);
    end
endmodule

// File: rtl/hcnt_top.sv
module hcnt_top
    import hcnt_pkg::*;
#(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         set,
    input  logic [W-1:0] set_val,
    input  logic         inc,
    input  logic         dec,
    input  logic [W-1:0] step,
    input  logic         commit,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         err
);
    op_e          op;
    logic [W-1:0] pri_q;
    logic [W-1:0] pri_n;
    logic [W-1:0] sec_q;
    logic [W-1:0] sec_n;

    hcnt_decode u_dec (
        .clr (clr),
        .set (set),
        .inc (inc),
        .dec (dec),
        .op  (op)
    );

    hcnt_lane #(.W(W), .RST_VAL(RST_VAL), .PRIMARY(1'b1)) u_pri (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .op       (op),
        .set_val  (set_val),
        .step     (step),
        .val_next (pri_n),
        .val_q    (pri_q)
    );

    hcnt_lane #(.W(W), .RST_VAL(RST_VAL), .PRIMARY(1'b0)) u_sec (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .op       (op),
        .set_val  (set_val),
        .step     (step),
        .val_next (sec_n),
        .val_q    (sec_q)
    );

    hcnt_check #(.W(W)) u_chk (
        .pri      (pri_q),
        .sec      (sec_q),
        .mismatch (err)
    );

    assign cnt      = pri_q;
    assign cnt_next = pri_n;
endmodule

// File: rtl/hcnt_top_sva.sv
module hcnt_top_sva #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input logic         clk,
    input logic         rst,
    input logic         clr,
    input logic         set,
    input logic [W-1:0] set_val,
    input logic         inc,
    input logic         dec,
    input logic [W-1:0] step,
    input logic         commit,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cnt_next,
    input logic         err,
    input logic [W-1:0] sec_q
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (cnt == RST_VAL) && !err);

    a_r8_hold_no_commit: assert property (@(posedge clk) disable iff (rst || err)
        !commit |=> $stable(cnt));

    a_r7_preview_lands: assert property (@(posedge clk) disable iff (rst || err)
        commit |=> cnt == $past(cnt_next));

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst || err)
        (commit && clr) |=> cnt == RST_VAL);

    a_r3_set_loads: assert property (@(posedge clk) disable iff (rst || err)
        (commit && set && !clr) |=> cnt == $past(set_val));

    a_r6_both_hold: assert property (@(posedge clk) disable iff (rst || err)
        (inc && dec && !clr && !set) |=> $stable(cnt) && $stable(sec_q));

    a_r4_top_sticks: assert property (@(posedge clk) disable iff (rst || err)
        (inc && !dec && !clr && !set && cnt == ONES) |=> $stable(cnt));

    a_r5_floor_sticks: assert property (@(posedge clk) disable iff (rst || err)
        (dec && !inc && !clr && !set && cnt == '0) |=> $stable(cnt));

    a_r10_shadow_floor: assert property (@(posedge clk) disable iff (rst || err)
        (inc && !dec && !clr && !set && sec_q == '0) |=> $stable(sec_q));
endmodule

bind hcnt_top hcnt_top_sva #(.W(W), .RST_VAL(RST_VAL)) u_sva (.*);

// File: tb/hcnt_top_test.sv
`timescale 1ns/1ps
module hcnt_top_test;
    localparam int           W    = 4;
    localparam logic [W-1:0] RSTV = 4'd3;
    localparam int           NV   = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr = 1'b0, set = 1'b0, inc = 1'b0, dec = 1'b0, commit = 1'b0;
    logic [W-1:0] set_val = '0, step = '0;
    logic [W-1:0] cnt, cnt_next;
    logic         err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    hcnt_top #(.W(W), .RST_VAL(RSTV)) uut (
        .clk(clk), .rst(rst), .clr(clr), .set(set), .set_val(set_val),
        .inc(inc), .dec(dec), .step(step), .commit(commit),
        .cnt(cnt), .cnt_next(cnt_next), .err(err)
    );

    // {clr,set,inc,dec,commit, set_val, step, expected preview, expected count}
    localparam logic [20:0] VEC [NV] = '{
        {5'b00101, 4'd0,  4'd2,  4'd5,  4'd5 },  // up 3->5
        {5'b00101, 4'd0,  4'd7,  4'd12, 4'd12},  // up 5->12
        {5'b00101, 4'd0,  4'd9,  4'd15, 4'd15},  // up past top, clamps
        {5'b00010, 4'd0,  4'd4,  4'd11, 4'd15},  // down staged, no commit
        {5'b00011, 4'd0,  4'd4,  4'd11, 4'd11},  // down 15->11
        {5'b00111, 4'd0,  4'd3,  4'd11, 4'd11},  // both directions
        {5'b01101, 4'd6,  4'd1,  4'd6,  4'd6 },  // set beats up
        {5'b00011, 4'd0,  4'd15, 4'd0,  4'd0 },  // down past zero, clamps
        {5'b00011, 4'd0,  4'd1,  4'd0,  4'd0 },  // down at floor
        {5'b11101, 4'd9,  4'd2,  4'd3,  4'd3 },  // clear beats set and up
        {5'b01000, 4'd14, 4'd0,  4'd14, 4'd3 },  // set staged, no commit
        {5'b01001, 4'd14, 4'd0,  4'd14, 4'd14},  // set committed
        {5'b00101, 4'd0,  4'd1,  4'd15, 4'd15},  // up by one to top
        {5'b10000, 4'd0,  4'd0,  4'd3,  4'd15},  // clear staged, no commit
        {5'b10001, 4'd0,  4'd0,  4'd3,  4'd3 }   // clear committed
    };
    localparam string TAG [NV] = '{
        "R4", "R4", "R4", "R8", "R5", "R6", "R3", "R5",
        "R5", "R2", "R8", "R3", "R4", "R8", "R2"
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        clr = 0; set = 0; inc = 0; dec = 0; commit = 0; set_val = '0; step = '0;
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "count after reset", int'(cnt), int'(RSTV));
        check("R1", "err after reset", int'(err), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {clr, set, inc, dec, commit} = VEC[i][20:16];
            set_val = VEC[i][15:12];
            step    = VEC[i][11:8];
            #1;
            check("R7", $sformatf("preview v%0d (%s)", i, TAG[i]), int'(cnt_next), int'(VEC[i][7:4]));
            @(posedge clk);
            #1;
            check(TAG[i], $sformatf("count v%0d", i), int'(cnt), int'(VEC[i][3:0]));
            check("R10", $sformatf("err v%0d", i), int'(err), 0);
        end

        // R9: corrupt the shadow register, error must show in the same cycle
        @(negedge clk);
        idle();
        force uut.u_sec.val_q = 4'd0;
        #1;
        check("R9", "err with corrupted shadow", int'(err), 1);
        release uut.u_sec.val_q;
        #1;
        check("R9", "err persists after release", int'(err), 1);
        @(negedge clk);
        clr = 1; commit = 1;
        @(posedge clk);
        #1;
        check("R9", "err cleared by committed clear", int'(err), 0);
        check("R2", "count after recovery clear", int'(cnt), int'(RSTV));

        // R1: reset from a non-base value
        @(negedge clk);
        idle();
        set = 1; set_val = 4'd10; commit = 1;
        @(negedge clk);
        idle();
        rst = 1;
        @(posedge clk);
        #1;
        check("R1", "count after mid-run reset", int'(cnt), int'(RSTV));
        @(negedge clk);
        rst = 0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule